// File: doc/BRIEF.md
# Synchronized Clock Divider Group

A set of integer clock dividers that all run from one shared fast source clock, with a group synchronization function. A sync request is the OR of an active-low external pin and an active-high software bit. The request is sampled by a slower system clock and then re-timed into the source clock domain through two flops. While the request stands, every participating channel stops at the end of its current output period and holds its output at 0. A participating channel has its sync enable set and a ratio of 2 or more. When the request is removed and every participating channel has stopped, all of them restart on the same source cycle, so their first rising edges coincide.

Channels with sync disabled keep running and never stop. Channels programmed for ratio 0 or 1 pass the source clock straight through and are never gated. Each channel reports a flag while it is held. A typical use keeps downstream devices free of clocks until they are configured, then releases a phase-aligned group.

Top module: `clk_div_group`

## Requirements
- R1: The sync request is (not `sync_pin_ni`) or `sync_sw_i`. It is sampled on the rising edge of `sys_clk_i` and then passes through two `clk_i` flops before it acts on the dividers.
- R2: While a participating channel is held, its `held_o` bit is 1 and its `clk_o` bit is 0.
- R3: Release happens once the re-timed request is low and every participating channel is held. All participating channels then leave hold on the same `clk_o` cycle, and each drives `clk_o` high in that first cycle. Once any participating channel is held, the rest still drain to hold, even if the request has already been withdrawn.
- R4: A running participating channel enters hold only at the last count of its period, a cycle in which its output is low. No high phase is ever shortened.
- R5: A channel with `sync_en_i` bit 0 ignores sync. Its `held_o` stays 0 and its output keeps dividing.
- R6: A channel with ratio 0 or 1 is a bypass: `clk_o` follows `clk_i` and `held_o` stays 0.
- R7: With ratio N ≥ 2, a running channel repeats a period of N source cycles. Its output is high for floor(N/2) of them, starting with the first cycle of the period.
- R8: During reset all `held_o` bits are 0 and every non-bypass `clk_o` bit is 0.
- R9: A low pulse on `sync_pin_ni` that spans no rising edge of `sys_clk_i` has no effect.
- R10: When every participating channel is already held and the request is removed, `held_o` falls at the third `clk_i` rising edge after the first `sys_clk_i` rising edge that samples the removed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared fast source clock |
| sys_clk_i | input | 1 | Slow system clock that samples the request |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_pin_ni | input | 1 | External sync request, active low |
| sync_sw_i | input | 1 | Software sync request, active high |
| ratio_i | input | NCH*CW | Divide ratio per channel; 0 or 1 selects bypass |
| sync_en_i | input | NCH | Per-channel sync participation |
| clk_o | output | NCH | Divided clock outputs |
| held_o | output | NCH | Per-channel flag, high while held by sync |

## Verification
The bench builds the block with five channels and 6-bit ratios. The channels hold ratios 2, 3, 6 and 4 plus one bypass channel, and the ratio-4 channel has sync disabled. Later the ratios change to the odd value 7, the even value 8 and 2. This mix makes every drain end on a different cycle for each channel, so the bench can check the aligned release across unequal periods. It also runs a free channel and a bypass channel through a sync, and tests a request withdrawn in the middle of a drain. The system clock runs at one eighth of the source rate with a fixed phase, so the bench can place a pin pulse between sampling edges and can count the release latency exactly.

// File: rtl/clk_div_group_pkg.sv
package clk_div_group_pkg;
  typedef enum logic {CH_RUN = 1'b0, CH_HOLD = 1'b1} ch_state_e;
endpackage

// File: rtl/cdg_req_sample.sv
module cdg_req_sample (
  input  logic sys_clk_i,
  input  logic rst_ni,
  input  logic sync_pin_ni,
  input  logic sync_sw_i,
  output logic req_o
);
  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= ~sync_pin_ni | sync_sw_i;
  end
endmodule

// File: rtl/cdg_retime.sv
module cdg_retime #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cdg_group_ctl.sv
module cdg_group_ctl #(
  parameter int NCH = 4
) (
  input  logic           stop_i,
  input  logic [NCH-1:0] held_i,
  input  logic [NCH-1:0] part_i,
  output logic           hold_req_o,
  output logic           release_o
);
  logic any_held, all_held;

  assign any_held   = |(held_i & part_i);
  assign all_held   = &(held_i | ~part_i);
  // keep draining once any member stopped, so a withdrawn request cannot strand it
  assign hold_req_o = stop_i | any_held;
  assign release_o  = ~stop_i & all_held;
endmodule

// File: rtl/cdg_div_ch.sv
module cdg_div_ch
  import clk_div_group_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] ratio_i,
  input  logic          en_i,
  input  logic          hold_req_i,
  input  logic          release_i,
  output logic          clk_o,
  output logic          held_o,
  output logic          part_o
);
  ch_state_e     st_q;
  logic [CW-1:0] cnt_q, cnt_nxt, half;
  logic          out_q, bypass, last;

  assign bypass  = ratio_i <= CW'(1);
  assign part_o  = en_i & ~bypass;
  assign half    = ratio_i >> 1;
  assign last    = cnt_q >= (ratio_i - CW'(1));
  assign cnt_nxt = last ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CH_RUN;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!part_o) begin
      st_q  <= CH_RUN;
      cnt_q <= cnt_nxt;
      out_q <= cnt_nxt < half;
    end else if (st_q == CH_HOLD) begin
      cnt_q <= '0;
      if (release_i) begin
        st_q  <= CH_RUN;
        out_q <= 1'b1;
      end else begin
        out_q <= 1'b0;
      end
    end else if (hold_req_i && last) begin
      st_q  <= CH_HOLD;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      out_q <= cnt_nxt < half;
    end
  end

  assign held_o = st_q == CH_HOLD;
  assign clk_o  = bypass ? clk_i : out_q;
endmodule

// File: rtl/clk_div_group.sv
module clk_div_group #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input  logic                clk_i,
  input  logic                sys_clk_i,
  input  logic                rst_ni,
  input  logic                sync_pin_ni,
  input  logic                sync_sw_i,
  input  logic [NCH-1:0][CW-1:0] ratio_i,
  input  logic [NCH-1:0]      sync_en_i,
  output logic [NCH-1:0]      clk_o,
  output logic [NCH-1:0]      held_o
);
  logic req_sys, stop, hold_req, release_s;
  logic [NCH-1:0] part;

  cdg_req_sample u_sample (
    .sys_clk_i  (sys_clk_i),
    .rst_ni     (rst_ni),
    .sync_pin_ni(sync_pin_ni),
    .sync_sw_i  (sync_sw_i),
    .req_o      (req_sys)
  );

  cdg_retime #(.STAGES(2)) u_retime (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_sys),
    .q_o   (stop)
  );

  cdg_group_ctl #(.NCH(NCH)) u_ctl (
    .stop_i    (stop),
    .held_i    (held_o),
    .part_i    (part),
    .hold_req_o(hold_req),
    .release_o (release_s)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cdg_div_ch #(.CW(CW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ratio_i   (ratio_i[g]),
      .en_i      (sync_en_i[g]),
      .hold_req_i(hold_req),
      .release_i (release_s),
      .clk_o     (clk_o[g]),
      .held_o    (held_o[g]),
      .part_o    (part[g])
    );
  end
endmodule

// File: rtl/clk_div_group_chk.sv
module clk_div_group_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NCH-1:0][CW-1:0] ratio_i,
  input logic [NCH-1:0]         sync_en_i,
  input logic [NCH-1:0]         clk_o,
  input logic [NCH-1:0]         held_o
);
  logic [NCH-1:0] member;
  for (genvar g = 0; g < NCH; g++) begin : g_m
    assign member[g] = sync_en_i[g] && (ratio_i[g] > CW'(1));
  end

  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r2_muted_while_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      held_o[g] |-> !clk_o[g]);
    a_r4_stop_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(held_o[g]) |-> !$past(clk_o[g]));
    a_r3_first_cycle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(held_o[g]) && member[g]) |-> clk_o[g]);
    a_r3_aligned_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(held_o[g]) && member[g]) |-> ((held_o & member) == '0));
    a_r5_nonmember_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !member[g] |=> !held_o[g]);
  end
endmodule

bind clk_div_group clk_div_group_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ratio_i  (ratio_i),
  .sync_en_i(sync_en_i),
  .clk_o    (clk_o),
  .held_o   (held_o)
);

// File: tb/sim_clk_div_group.sv
`timescale 1ns/1ps
module sim_clk_div_group;
  localparam int NCH = 5;
  localparam int CW  = 6;

  logic clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic pin_n = 1'b1, sw = 1'b0;
  logic [NCH-1:0][CW-1:0] ratio;
  logic [NCH-1:0] en;
  logic [NCH-1:0] clk_o, held_o;

  int total = 0, bad = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  clk_div_group #(.NCH(NCH), .CW(CW)) u0 (
    .clk_i(clk), .sys_clk_i(sys_clk), .rst_ni(rst_n),
    .sync_pin_ni(pin_n), .sync_sw_i(sw),
    .ratio_i(ratio), .sync_en_i(en),
    .clk_o(clk_o), .held_o(held_o)
  );

  always #2.5 clk = ~clk;
  initial begin
    #5;
    forever #20 sys_clk = ~sys_clk;
  end

  // behavioural reference
  bit m_req, m_s1, m_s2;
  int m_ph[NCH];
  bit m_out[NCH], m_held[NCH];

  function automatic bit is_member(int i);
    return en[i] && (int'(ratio[i]) > 1);
  endfunction

  always @(posedge sys_clk or negedge rst_n)
    if (!rst_n) m_req <= 1'b0;
    else        m_req <= !pin_n || sw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
      for (int i = 0; i < NCH; i++) begin m_ph[i] = 0; m_out[i] = 0; m_held[i] = 0; end
    end else begin
      bit any_h, all_h, hreq, rel;
      any_h = 0; all_h = 1;
      for (int i = 0; i < NCH; i++) begin
        if (is_member(i) && m_held[i]) any_h = 1;
        if (is_member(i) && !m_held[i]) all_h = 0;
      end
      hreq = m_s2 || any_h;
      rel  = !m_s2 && all_h;
      for (int i = 0; i < NCH; i++) begin
        int n;
        bit endp;
        n = int'(ratio[i]);
        endp = m_ph[i] >= n - 1;
        if (!is_member(i)) begin
          m_held[i] = 0;
          m_ph[i] = endp ? 0 : m_ph[i] + 1;
          m_out[i] = m_ph[i] < n / 2;
        end else if (m_held[i]) begin
          m_ph[i] = 0;
          if (rel) begin m_held[i] = 0; m_out[i] = 1; end
          else m_out[i] = 0;
        end else if (hreq && endp) begin
          m_held[i] = 1; m_ph[i] = 0; m_out[i] = 0;
        end else begin
          m_ph[i] = endp ? 0 : m_ph[i] + 1;
          m_out[i] = m_ph[i] < n / 2;
        end
      end
      m_s2 = m_s1;
      m_s1 = m_req;
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      for (int i = 0; i < NCH; i++) begin
        bit eo;
        eo = (int'(ratio[i]) <= 1) ? 1'b1 : m_out[i];
        total++;
        if (clk_o[i] !== eo) begin
          bad++;
          $display("FAIL R7 ch%0d clk_o actual=%b expected=%b t=%0t", i, clk_o[i], eo, $time);
        end
        total++;
        if (held_o[i] !== m_held[i]) begin
          bad++;
          $display("FAIL R2 ch%0d held_o actual=%b expected=%b t=%0t", i, held_o[i], m_held[i], $time);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic count_high(int ch, int n, output int c);
    c = 0;
    repeat (n) begin
      @(posedge clk); #2;
      if (clk_o[ch]) c++;
    end
    #1;
  endtask

  function automatic logic [NCH-1:0] members();
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = is_member(i);
    return m;
  endfunction

  initial begin
    int c, seen;
    ratio[0] = 6'd2; ratio[1] = 6'd3; ratio[2] = 6'd6; ratio[3] = 6'd1; ratio[4] = 6'd4;
    en = 5'b01111;
    cyc(3);
    #1;
    chk("R8 held_o in reset", 32'(held_o), 32'h0);
    chk("R8 clk_o in reset", 32'(clk_o & 5'b10111), 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    cyc(30);

    count_high(2, 6, c); chk("R7 ratio 6 high count", 32'(c), 32'd3);
    count_high(1, 3, c); chk("R7 ratio 3 high count", 32'(c), 32'd1);

    pin_n = 1'b0;                       // R1 pin request
    cyc(60);
    chk("R1 R2 pin request holds members", 32'(held_o & members()), 32'(members()));
    chk("R2 members muted", 32'(clk_o & members()), 32'h0);
    chk("R5 disabled channel not held", 32'(held_o[4]), 32'h0);
    count_high(4, 4, c); chk("R5 disabled channel keeps dividing", 32'(c), 32'd2);
    @(posedge clk); #2;
    chk("R6 bypass follows clk_i", 32'(clk_o[3]), 32'h1);
    chk("R6 bypass not held", 32'(held_o[3]), 32'h0);

    // R10 release latency, all members already held
    @(posedge sys_clk); @(posedge clk); #1 pin_n = 1'b1;
    @(posedge sys_clk);
    repeat (2) @(posedge clk);
    #2 chk("R10 still held two edges after sample", 32'(held_o & members()), 32'(members()));
    @(posedge clk); #2;
    chk("R10 R3 released at third edge", 32'(held_o & members()), 32'h0);
    chk("R3 all members high on first cycle", 32'(clk_o & members()), 32'(members()));
    cyc(20);

    sw = 1'b1;                          // R1 software request
    cyc(60);
    chk("R1 software bit holds members", 32'(held_o & members()), 32'(members()));
    sw = 1'b0;
    cyc(40);
    chk("R1 software release", 32'(held_o), 32'h0);

    // R9 short pin pulse between sampling edges
    @(posedge sys_clk); @(posedge clk); #1 pin_n = 1'b0;
    cyc(2); pin_n = 1'b1;
    seen = 0;
    repeat (60) begin @(posedge clk); #2; if (held_o != '0) seen++; end
    chk("R9 short pulse ignored", 32'(seen), 32'h0);

    ratio[0] = 6'd7; ratio[1] = 6'd8; ratio[2] = 6'd2;
    cyc(20);
    count_high(0, 7, c); chk("R7 odd ratio 7 high count", 32'(c), 32'd3);
    count_high(1, 8, c); chk("R7 even ratio 8 high count", 32'(c), 32'd4);

    // R3/R4 request withdrawn during drain: one sampled sys period only
    @(posedge sys_clk); @(posedge clk); #1 pin_n = 1'b0;
    @(posedge sys_clk); @(posedge clk); #1 pin_n = 1'b1;
    seen = 0;
    repeat (60) begin @(posedge clk); #2; if ((held_o & members()) == members()) seen++; end
    chk("R3 drain completes for whole group", 32'(seen > 0), 32'h1);
    chk("R3 group released after drain", 32'(held_o), 32'h0);

    en = '0;                            // R5 nobody participates
    sw = 1'b1;
    seen = 0;
    repeat (50) begin @(posedge clk); #2; if (held_o != '0) seen++; end
    chk("R5 sync ignored with enables clear", 32'(seen), 32'h0);
    sw = 1'b0;
    cyc(10);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule